// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Bridge

This block sits between a 4 KB memory-mapped bus window and the register interface of an ATA disk controller model. Each bus access arrives on a valid/ready handshake with a size code. The bridge takes the register index from the address bits above the 16-byte stride. It sends the access to the right device register as a one-cycle read or write strobe, together with a register-select code.

Byte accesses reach the command-block registers and the device-control / alternate-status register. Halfword and word accesses reach only the data port. Both directions of data-port traffic are byte-reversed, because the bus is big-endian and the ATA data path is little-endian. Accesses that hit no register complete on the bus with all-ones read data and cause no device strobe. Read data comes back one cycle after the access is accepted. A new access can be accepted in every cycle.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits at or above bit 12 and bits [3:0] have no effect on decode.
- R2: A byte access (size code 0) at index 1 to 7 strobes the device with `dev_sel` equal to the index. A write carries `bus_wdata[7:0]` in `dev_wdata[7:0]` with the upper bits zero. A read returns `dev_rdata[7:0]` in `rsp_rdata[7:0]` with the upper bits zero.
- R3: A byte access at index 8 or index 22 uses `dev_sel` = 8. A write reaches device control, and a read returns the alternate status that leaves the interrupt untouched.
- R4: A byte access at any other index, including index 0, strobes nothing. A read returns 0x000000FF.
- R5: A halfword (size code 1) or word (size code 2) access at a nonzero index strobes nothing. A read returns 0x0000FFFF or 0xFFFFFFFF respectively.
- R6: At index 0, a halfword uses `dev_sel` = 0 and swaps its two bytes in both directions, with the upper 16 bits zero. A word uses `dev_sel` = 0 and reverses all four bytes in both directions.
- R7: Size code 3 is reserved. It strobes nothing, and a read returns 0xFFFFFFFF.
- R8: While `rst` is high, and for one cycle after it falls, `dev_reset` is high and `bus_ready` is low. Reset removes any pending strobe and any pending response, even for an access accepted in the same cycle.
- R9: The strobe and, for reads, `rsp_valid` are high for exactly the one cycle after acceptance. `dev_rd` and `dev_wr` are never high together. Back-to-back accesses are accepted in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access request |
| bus_ready | output | 1 | Bridge can accept an access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| dev_reset | output | 1 | Reset pulse toward the device model |
| dev_rd | output | 1 | Device register read strobe |
| dev_wr | output | 1 | Device register write strobe |
| dev_sel | output | 4 | Register select: 0 data, 1-7 command block, 8 control/alt status |
| dev_wdata | output | 32 | Write data toward the device |
| dev_rdata | input | 32 | Read data from the device, valid while `dev_rd` is high |

## Verification
Two functions can meet in one cycle. The response to one read leaves the bridge in the same cycle that the next access is accepted, and a reset can land on the edge that accepts an access. The bench issues two reads in consecutive cycles and checks that each response carries its own register's data and byte order. It then raises reset in the same cycle as a valid request, and checks that neither a strobe nor a response comes out while the reset pulse holds.

// File: rtl/mmio_ata_pkg.sv
`timescale 1ns/1ps
package mmio_ata_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int SEL_W    = 4;
   localparam int SEL_DATA = 0;
   localparam int SEL_CTL  = 8;
   localparam int CMD_LAST = 7;
endpackage

// File: rtl/mmio_ata_decode.sv
`timescale 1ns/1ps
module mmio_ata_decode
   import mmio_ata_pkg::*;
#(
   parameter int WIN_BITS    = 12,
   parameter int STRIDE_BITS = 4,
   parameter int CTL_IDX_A   = 8,
   parameter int CTL_IDX_B   = 22
) (
   input  logic [WIN_BITS-1:0] addr,
   input  acc_size_e           size,
   output logic                hit,
   output logic [SEL_W-1:0]    sel
);
   localparam int IDX_W = WIN_BITS - STRIDE_BITS;

   generate
      if (IDX_W < SEL_W) begin : g_bad_idx
         $error("index field narrower than register select");
      end
      if (CTL_IDX_A >= (1 << IDX_W) || CTL_IDX_B >= (1 << IDX_W)) begin : g_bad_ctl
         $error("control slot outside window");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             ctl_hit;
   logic             cmd_hit;

   assign idx = addr[WIN_BITS-1:STRIDE_BITS];

   generate
      if (CTL_IDX_A == CTL_IDX_B) begin : g_one_ctl
         assign ctl_hit = (idx == IDX_W'(CTL_IDX_A));
      end else begin : g_two_ctl
         assign ctl_hit = (idx == IDX_W'(CTL_IDX_A)) || (idx == IDX_W'(CTL_IDX_B));
      end
   endgenerate

   assign cmd_hit = (idx != '0) && (idx <= IDX_W'(CMD_LAST));

   always_comb begin
      hit = 1'b0;
      sel = SEL_W'(SEL_DATA);
      unique case (size)
         SZ_BYTE: begin
            if (cmd_hit) begin
               hit = 1'b1;
               sel = idx[SEL_W-1:0];
            end else if (ctl_hit) begin
               hit = 1'b1;
               sel = SEL_W'(SEL_CTL);
            end
         end
         SZ_HALF, SZ_WORD: begin
            hit = (idx == '0);
         end
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/mmio_ata_swap.sv
`timescale 1ns/1ps
module mmio_ata_swap #(
   parameter int BYTES   = 2,
   parameter bit REVERSE = 1'b1
) (
   input  logic [8*BYTES-1:0] din,
   output logic [8*BYTES-1:0] dout
);
   generate
      if (BYTES < 1) begin : g_bad
         $error("swap needs at least one byte");
      end
      for (genvar i = 0; i < BYTES; i++) begin : g_lane
         if (REVERSE) begin : g_rev
            assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
         end else begin : g_pass
            assign dout[8*i +: 8] = din[8*i +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/mmio_ata_lane.sv
`timescale 1ns/1ps
module mmio_ata_lane
   import mmio_ata_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit BIG_BUS  = 1'b1
) (
   input  acc_size_e         wr_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] dev_wdata,
   input  acc_size_e         rd_size,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic [DATA_W-1:0] rd_result
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("lane logic is built for a 32-bit bus");
      end
   endgenerate

   logic [HALF_W-1:0] wr_half_sw, rd_half_sw;
   logic [DATA_W-1:0] wr_word_sw, rd_word_sw;

   mmio_ata_swap #(.BYTES(HALF_W/8), .REVERSE(BIG_BUS)) u_wr_half (
      .din(bus_wdata[HALF_W-1:0]), .dout(wr_half_sw));
   mmio_ata_swap #(.BYTES(DATA_W/8), .REVERSE(BIG_BUS)) u_wr_word (
      .din(bus_wdata), .dout(wr_word_sw));
   mmio_ata_swap #(.BYTES(HALF_W/8), .REVERSE(BIG_BUS)) u_rd_half (
      .din(dev_rdata[HALF_W-1:0]), .dout(rd_half_sw));
   mmio_ata_swap #(.BYTES(DATA_W/8), .REVERSE(BIG_BUS)) u_rd_word (
      .din(dev_rdata), .dout(rd_word_sw));

   always_comb begin
      unique case (wr_size)
         SZ_BYTE: dev_wdata = {{(DATA_W-8){1'b0}}, bus_wdata[7:0]};
         SZ_HALF: dev_wdata = {{HALF_W{1'b0}}, wr_half_sw};
         SZ_WORD: dev_wdata = wr_word_sw;
         default: dev_wdata = '0;
      endcase
   end

   always_comb begin
      unique case (rd_size)
         SZ_BYTE: rd_result = rd_hit ? {{(DATA_W-8){1'b0}}, dev_rdata[7:0]}
                                     : {{(DATA_W-8){1'b0}}, 8'hFF};
         SZ_HALF: rd_result = rd_hit ? {{HALF_W{1'b0}}, rd_half_sw}
                                     : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
         SZ_WORD: rd_result = rd_hit ? rd_word_sw : '1;
         default: rd_result = '1;
      endcase
   end
endmodule

// File: rtl/mmio_ata_bridge.sv
`timescale 1ns/1ps
module mmio_ata_bridge
   import mmio_ata_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WIN_BITS    = 12,
   parameter int STRIDE_BITS = 4,
   parameter int CTL_IDX_A   = 8,
   parameter int CTL_IDX_B   = 22
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_valid,
   output logic              bus_ready,
   input  logic              bus_write,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              dev_reset,
   output logic              dev_rd,
   output logic              dev_wr,
   output logic [3:0]        dev_sel,
   output logic [31:0]       dev_wdata,
   input  logic [31:0]       dev_rdata
);
   localparam int DATA_W = 32;

   generate
      if (ADDR_W < WIN_BITS) begin : g_bad_addr
         $error("address narrower than window");
      end
      if (WIN_BITS <= STRIDE_BITS) begin : g_bad_win
         $error("window must exceed stride");
      end
   endgenerate

   logic              accept;
   acc_size_e         cur_size;
   logic              dec_hit;
   logic [SEL_W-1:0]  dec_sel;
   logic [DATA_W-1:0] lane_wdata;
   logic [DATA_W-1:0] lane_rdata;

   logic              pend_rd, pend_wr, rsp_q, rsp_hit;
   acc_size_e         rsp_size;
   logic [SEL_W-1:0]  pend_sel;
   logic [DATA_W-1:0] pend_wdata;
   logic              rst_d, rst_pulse;

   logic unused_addr_bits;
   assign unused_addr_bits = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_addr[STRIDE_BITS-1:0]};

   assign cur_size  = acc_size_e'(bus_size);
   assign bus_ready = ~rst_pulse;
   assign accept    = bus_valid & bus_ready;

   mmio_ata_decode #(
      .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
      .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B)
   ) u_decode (
      .addr(bus_addr[WIN_BITS-1:0]), .size(cur_size),
      .hit(dec_hit), .sel(dec_sel)
   );

   mmio_ata_lane #(.DATA_W(DATA_W), .BIG_BUS(1'b1)) u_lane (
      .wr_size(cur_size), .bus_wdata(bus_wdata), .dev_wdata(lane_wdata),
      .rd_size(rsp_size), .rd_hit(rsp_hit), .dev_rdata(dev_rdata),
      .rd_result(lane_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rst_d     <= 1'b1;
         rst_pulse <= 1'b1;
      end else begin
         rst_d     <= 1'b0;
         rst_pulse <= rst_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_rd    <= 1'b0;
         pend_wr    <= 1'b0;
         rsp_q      <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_size   <= SZ_BYTE;
         pend_sel   <= '0;
         pend_wdata <= '0;
      end else begin
         pend_rd <= accept & ~bus_write & dec_hit;
         pend_wr <= accept &  bus_write & dec_hit;
         rsp_q   <= accept & ~bus_write;
         if (accept) begin
            pend_sel   <= dec_sel;
            pend_wdata <= lane_wdata;
            rsp_size   <= cur_size;
            rsp_hit    <= dec_hit;
         end
      end
   end

   assign dev_reset = rst_pulse;
   assign dev_rd    = pend_rd;
   assign dev_wr    = pend_wr;
   assign dev_sel   = pend_sel;
   assign dev_wdata = pend_wdata;
   assign rsp_valid = rsp_q;
   assign rsp_rdata = rsp_q ? lane_rdata : '0;

   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
      !(dev_rd && dev_wr));

   p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_ready && !bus_write) |=> rsp_valid);

   p_unmapped_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (accept && !dec_hit) |=> (!dev_rd && !dev_wr));

   p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> (!dev_rd && !dev_wr && !rsp_valid));

   p_reset_pulse_r8: assert property (@(posedge clk)
      $fell(rst) |-> dev_reset);

   p_reset_holds_off_r8: assert property (@(posedge clk)
      rst |=> !bus_ready);
endmodule

// File: tb/mmio_ata_bridge_bench.sv
`timescale 1ns/1ps
module mmio_ata_bridge_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [1:0]  bus_size = 2'd0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic        bus_ready, rsp_valid, dev_reset, dev_rd, dev_wr;
   logic [31:0] rsp_rdata, dev_wdata, dev_rdata;
   logic [3:0]  dev_sel;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   // device model: data port word fixed, other registers 0xABCDEF in upper bits, 0x50+sel low
   assign dev_rdata = (dev_sel == 4'd0) ? 32'hC1D2E3F4 : {24'hABCDEF, 8'h50 + {4'h0, dev_sel}};

   mmio_ata_bridge u_mmio_ata_bridge (
      .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
      .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .dev_reset(dev_reset), .dev_rd(dev_rd), .dev_wr(dev_wr),
      .dev_sel(dev_sel), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [31:0] addr;
      logic [31:0] wd;
      logic [1:0]  kind;   // 0 none, 1 read strobe, 2 write strobe
      logic [3:0]  sel;
      logic [31:0] exp;    // expected dev_wdata (write) or rsp_rdata (read)
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, 32'h0000_0010, 32'h0,        2'd1, 4'd1, 32'h0000_0051, 8'd2},  // R2
      '{1'b1, 2'd0, 32'h0000_0070, 32'hFFFFFF5A, 2'd2, 4'd7, 32'h0000_005A, 8'd2},  // R2
      '{1'b1, 2'd0, 32'h0000_0080, 32'h0000_0006, 2'd2, 4'd8, 32'h0000_0006, 8'd3}, // R3
      '{1'b0, 2'd0, 32'h0000_0160, 32'h0,        2'd1, 4'd8, 32'h0000_0058, 8'd3},  // R3
      '{1'b0, 2'd0, 32'h0000_0000, 32'h0,        2'd0, 4'd0, 32'h0000_00FF, 8'd4},  // R4
      '{1'b0, 2'd0, 32'h0000_0FF8, 32'h0,        2'd0, 4'd0, 32'h0000_00FF, 8'd4},  // R4
      '{1'b1, 2'd0, 32'h0000_0090, 32'h0000_0011, 2'd0, 4'd0, 32'h0,         8'd4}, // R4
      '{1'b0, 2'd1, 32'h0000_0010, 32'h0,        2'd0, 4'd0, 32'h0000_FFFF, 8'd5},  // R5
      '{1'b1, 2'd2, 32'h0000_0020, 32'h1234_5678, 2'd0, 4'd0, 32'h0,         8'd5}, // R5
      '{1'b0, 2'd2, 32'h0000_0030, 32'h0,        2'd0, 4'd0, 32'hFFFF_FFFF, 8'd5},  // R5
      '{1'b0, 2'd1, 32'h0000_0000, 32'h0,        2'd1, 4'd0, 32'h0000_F4E3, 8'd6},  // R6
      '{1'b1, 2'd1, 32'h0000_0000, 32'hFFFF_1234, 2'd2, 4'd0, 32'h0000_3412, 8'd6}, // R6
      '{1'b0, 2'd2, 32'h0000_0000, 32'h0,        2'd1, 4'd0, 32'hF4E3_D2C1, 8'd6},  // R6
      '{1'b1, 2'd2, 32'h0000_0000, 32'hA1B2_C3D4, 2'd2, 4'd0, 32'hD4C3_B2A1, 8'd6}, // R6
      '{1'b0, 2'd0, 32'hFFFF_F035, 32'h0,        2'd1, 4'd3, 32'h0000_0053, 8'd1},  // R1
      '{1'b0, 2'd3, 32'h0000_0000, 32'h0,        2'd0, 4'd0, 32'hFFFF_FFFF, 8'd7}   // R7
   };

   task automatic check(input string what, input int req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd);
      bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
   endtask

   task automatic expect_result(input vec_t v);
      int r;
      r = int'(v.req);
      check("read strobe", r, {31'd0, dev_rd}, {31'd0, v.kind == 2'd1});
      check("write strobe", r, {31'd0, dev_wr}, {31'd0, v.kind == 2'd2});
      if (v.kind != 2'd0) check("select", r, {28'd0, dev_sel}, {28'd0, v.sel});
      check("response valid", r, {31'd0, rsp_valid}, {31'd0, !v.wr});
      if (v.wr && v.kind == 2'd2) check("device write data", r, dev_wdata, v.exp);
      if (!v.wr) check("read data", r, rsp_rdata, v.exp);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      vec_t va, vb;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("reset pulse in reset", 8, {31'd0, dev_reset}, 32'd1);
      check("ready low in reset", 8, {31'd0, bus_ready}, 32'd0);
      check("no strobe in reset", 8, {30'd0, dev_rd, dev_wr}, 32'd0);
      check("no response in reset", 8, {31'd0, rsp_valid}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("pulse one cycle past reset R8", 8, {31'd0, dev_reset}, 32'd1);
      check("ready still low R8", 8, {31'd0, bus_ready}, 32'd0);
      @(negedge clk);
      check("pulse ended R8", 8, {31'd0, dev_reset}, 32'd0);
      check("ready high R8", 8, {31'd0, bus_ready}, 32'd1);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd);
         @(negedge clk);
         bus_valid = 1'b0;
         expect_result(VECS[i]);
         @(negedge clk);
      end

      // R9: back-to-back reads, each response carries its own data
      va = '{1'b0, 2'd1, 32'h0, 32'h0, 2'd1, 4'd0, 32'h0000_F4E3, 8'd9};
      vb = '{1'b0, 2'd0, 32'h20, 32'h0, 2'd1, 4'd2, 32'h0000_0052, 8'd9};
      drive(va.wr, va.sz, va.addr, va.wd);
      @(negedge clk);
      expect_result(va);
      drive(vb.wr, vb.sz, vb.addr, vb.wd);
      @(negedge clk);
      bus_valid = 1'b0;
      expect_result(vb);
      @(negedge clk);
      check("strobe lasts one cycle R9", 9, {30'd0, dev_rd, dev_wr}, 32'd0);
      check("response lasts one cycle R9", 9, {31'd0, rsp_valid}, 32'd0);

      // R8: reset lands on the accepting edge
      drive(1'b1, 2'd0, 32'h10, 32'h77);
      rst = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0;
      check("reset drops accepted write R8", 8, {30'd0, dev_rd, dev_wr}, 32'd0);
      check("reset drops response R8", 8, {31'd0, rsp_valid}, 32'd0);
      check("reset pulse raised R8", 8, {31'd0, dev_reset}, 32'd1);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check("ready after reset R8", 8, {31'd0, bus_ready}, 32'd1);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule